// File: doc/BRIEF.md
# Bus Transaction Trace Trigger Unit

This block sits beside a system bus and watches each transaction without taking part in it. Each transaction has an address, write data, a direction flag and the ID of the master that issued it. A set of address window comparators and one masked master-ID comparator turn the transaction into trigger bits. A programmable matrix combines the triggers into events, and each event is the AND of the triggers selected for it. Events are routed to two capture actions. One action records the write address and the other records the write value. The records wait in a small FIFO until a trace consumer takes them.

The usual way to use it is to narrow capture to one variable and one master. One window covers the variable's address range. The master comparator selects one ID, for example 0x2. Both triggers are mapped to the same event, and that event is routed to both capture actions. All configuration is held on static input ports.

Top module: `bus_trace_trig`

## Requirements
- R1: Window comparator k raises its trigger when its enable bit is set and lo_k <= address <= hi_k, with both bounds included. This holds for reads and writes from any master. When the enable bit is clear, the trigger stays low.
- R2: The master comparator forms m = mid & mask and r = ref & mask, then applies the mode. Mode 0 tests m == r, mode 1 tests m >= r, mode 2 tests m <= r and mode 3 tests m != r. When its enable bit is clear, its trigger stays low.
- R3: Trigger t of event e is selected by map bit e*N_TRIG+t. Windows take trigger indices 0..N_WIN-1 and the master comparator takes index N_WIN. An event is active only when every selected trigger is active in the same transaction. An event with no selected triggers is never active.
- R4: A transaction captures the address when any active event has its address-route bit set. It captures the data when any active event has its data-route bit set. It produces one record with tag 1 (address only, data field 0), tag 2 (data only, address field 0) or tag 3 (both).
- R5: Only write transactions produce records. A read that activates events produces nothing.
- R6: A transaction sampled with bus_valid at clock edge N appears at the FIFO output after edge N+2, provided the FIFO is empty.
- R7: Records leave the FIFO in arrival order and stay stable while rec_ready is low. The FIFO holds FIFO_DEPTH (default 8) records.
- R8: A record that arrives when the FIFO is full and no pop happens in that cycle is dropped. Dropping a record sets overflow, which stays set until reset.
- R9: After reset the FIFO is empty and overflow is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Transaction strobe |
| bus_addr | input | ADDR_W | Transaction address |
| bus_wdata | input | DATA_W | Write data |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_mid | input | MID_W | Master ID |
| cfg_win_en | input | N_WIN | Window comparator enables |
| cfg_win_lo | input | N_WIN*ADDR_W | Lower bounds, window k at bits k*ADDR_W |
| cfg_win_hi | input | N_WIN*ADDR_W | Upper bounds, same packing |
| cfg_mid_en | input | 1 | Master comparator enable |
| cfg_mid_ref | input | MID_W | Master reference value |
| cfg_mid_mask | input | MID_W | Master compare mask |
| cfg_mid_mode | input | 2 | Compare mode, see R2 |
| cfg_evt_map | input | N_EVT*(N_WIN+1) | Trigger-to-event selection |
| cfg_route_adr | input | N_EVT | Events routed to address capture |
| cfg_route_dat | input | N_EVT | Events routed to data capture |
| rec_valid | output | 1 | FIFO holds a record |
| rec_ready | input | 1 | Consumer takes the head record |
| rec_tag | output | 2 | Record content tag, see R4 |
| rec_addr | output | ADDR_W | Captured address |
| rec_data | output | DATA_W | Captured write value |
| overflow | output | 1 | Sticky record-drop flag |

## Verification
The hardest state to reach is a full FIFO that then drops a record. The bench reaches it by holding rec_ready low and issuing nine qualifying writes. It confirms that overflow stays low through the eighth write and rises on the ninth. It then drains the FIFO and checks that exactly the first eight records come out in order, with the flag still set. The AND matrix has a second hard case: one transaction must match the window while the master comparator rejects it. The bench changes only the master ID across otherwise identical writes to reach it.

// File: rtl/bus_trace_pkg.sv
package bus_trace_pkg;

    typedef enum logic [1:0] {
        TAG_NONE = 2'd0,
        TAG_ADDR = 2'd1,
        TAG_DATA = 2'd2,
        TAG_BOTH = 2'd3
    } rec_tag_e;

    typedef enum logic [1:0] {
        MID_EQ = 2'd0,
        MID_GE = 2'd1,
        MID_LE = 2'd2,
        MID_NE = 2'd3
    } mid_mode_e;

endpackage

// File: rtl/btt_addr_cmp.sv
module btt_addr_cmp #(
    parameter int ADDR_W = 32,
    parameter int N_WIN  = 2
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [N_WIN-1:0]        win_en,
    input  logic [N_WIN*ADDR_W-1:0] win_lo,
    input  logic [N_WIN*ADDR_W-1:0] win_hi,
    output logic [N_WIN-1:0]        hit
);

    for (genvar k = 0; k < N_WIN; k++) begin : g_win
        logic [ADDR_W-1:0] lo_k;
        logic [ADDR_W-1:0] hi_k;
        assign lo_k = win_lo[k*ADDR_W +: ADDR_W];
        assign hi_k = win_hi[k*ADDR_W +: ADDR_W];
        always_comb begin
            hit[k] = win_en[k] && (addr >= lo_k) && (addr <= hi_k);
        end
    end

endmodule

// File: rtl/btt_mid_cmp.sv
module btt_mid_cmp
    import bus_trace_pkg::*;
#(
    parameter int MID_W = 4
) (
    input  logic             en,
    input  logic [MID_W-1:0] mid,
    input  logic [MID_W-1:0] ref_val,
    input  logic [MID_W-1:0] mask,
    input  logic [1:0]       mode,
    output logic             hit
);

    logic [MID_W-1:0] m_masked;
    logic [MID_W-1:0] r_masked;
    logic             rel;

    always_comb begin
        m_masked = mid & mask;
        r_masked = ref_val & mask;
        case (mid_mode_e'(mode))
            MID_EQ:  rel = (m_masked == r_masked);
            MID_GE:  rel = (m_masked >= r_masked);
            MID_LE:  rel = (m_masked <= r_masked);
            default: rel = (m_masked != r_masked);
        endcase
        hit = en && rel;
    end

endmodule

// File: rtl/btt_evt_route.sv
module btt_evt_route #(
    parameter int N_TRIG = 3,
    parameter int N_EVT  = 4
) (
    input  logic [N_TRIG-1:0]       trig,
    input  logic [N_EVT*N_TRIG-1:0] evt_map,
    input  logic [N_EVT-1:0]        route_adr,
    input  logic [N_EVT-1:0]        route_dat,
    output logic                    fire_adr,
    output logic                    fire_dat
);

    logic [N_EVT-1:0] evt;

    for (genvar e = 0; e < N_EVT; e++) begin : g_evt
        logic [N_TRIG-1:0] sel;
        assign sel = evt_map[e*N_TRIG +: N_TRIG];
        always_comb begin
            evt[e] = (|sel) && ((trig & sel) == sel);
        end
    end

    always_comb begin
        fire_adr = |(evt & route_adr);
        fire_dat = |(evt & route_dat);
    end

endmodule

// File: rtl/btt_rec_fifo.sv
module btt_rec_fifo #(
    parameter int WIDTH = 66,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_push, do_pop, full;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        full    = (st_q.cnt == CNT_W'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        do_push = push && (!full || do_pop);
        if (push && !do_push) begin
            st_d.ovf = 1'b1;
        end
        if (do_push) begin
            mem_d[st_q.wr] = push_data;
            st_d.wr        = ptr_inc(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = ptr_inc(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_data  = mem_q[st_q.rd];
    assign overflow  = st_q.ovf;

endmodule

// File: rtl/bus_trace_trig.sv
module bus_trace_trig
    import bus_trace_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int MID_W      = 4,
    parameter int N_WIN      = 2,
    parameter int N_EVT      = 4,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_valid,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    input  logic                             bus_write,
    input  logic [MID_W-1:0]                 bus_mid,
    input  logic [N_WIN-1:0]                 cfg_win_en,
    input  logic [N_WIN*ADDR_W-1:0]          cfg_win_lo,
    input  logic [N_WIN*ADDR_W-1:0]          cfg_win_hi,
    input  logic                             cfg_mid_en,
    input  logic [MID_W-1:0]                 cfg_mid_ref,
    input  logic [MID_W-1:0]                 cfg_mid_mask,
    input  logic [1:0]                       cfg_mid_mode,
    input  logic [N_EVT*(N_WIN+1)-1:0]       cfg_evt_map,
    input  logic [N_EVT-1:0]                 cfg_route_adr,
    input  logic [N_EVT-1:0]                 cfg_route_dat,
    output logic                             rec_valid,
    input  logic                             rec_ready,
    output logic [1:0]                       rec_tag,
    output logic [ADDR_W-1:0]                rec_addr,
    output logic [DATA_W-1:0]                rec_data,
    output logic                             overflow
);

    localparam int N_TRIG = N_WIN + 1;
    localparam int REC_W  = 2 + ADDR_W + DATA_W;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [MID_W-1:0]  mid;
    } txn_t;

    txn_t              txn_d, txn_q;
    logic [N_WIN-1:0]  win_hit;
    logic              mid_hit;
    logic [N_TRIG-1:0] trig;
    logic              fire_adr, fire_dat;
    logic              cap_push;
    logic [REC_W-1:0]  cap_rec;
    logic [REC_W-1:0]  head_rec;

    // stage 1: register the observed transaction
    always_comb begin
        txn_d       = txn_q;
        txn_d.valid = bus_valid;
        if (bus_valid) begin
            txn_d.write = bus_write;
            txn_d.addr  = bus_addr;
            txn_d.data  = bus_wdata;
            txn_d.mid   = bus_mid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txn_q <= '0;
        end else begin
            txn_q <= txn_d;
        end
    end

    btt_addr_cmp #(
        .ADDR_W (ADDR_W),
        .N_WIN  (N_WIN)
    ) u_win (
        .addr   (txn_q.addr),
        .win_en (cfg_win_en),
        .win_lo (cfg_win_lo),
        .win_hi (cfg_win_hi),
        .hit    (win_hit)
    );

    btt_mid_cmp #(
        .MID_W (MID_W)
    ) u_mid (
        .en      (cfg_mid_en),
        .mid     (txn_q.mid),
        .ref_val (cfg_mid_ref),
        .mask    (cfg_mid_mask),
        .mode    (cfg_mid_mode),
        .hit     (mid_hit)
    );

    assign trig = {mid_hit, win_hit};

    btt_evt_route #(
        .N_TRIG (N_TRIG),
        .N_EVT  (N_EVT)
    ) u_route (
        .trig      (trig),
        .evt_map   (cfg_evt_map),
        .route_adr (cfg_route_adr),
        .route_dat (cfg_route_dat),
        .fire_adr  (fire_adr),
        .fire_dat  (fire_dat)
    );

    // stage 2: build the record and hand it to the FIFO
    always_comb begin
        cap_push = txn_q.valid && txn_q.write && (fire_adr || fire_dat);
        cap_rec  = {fire_dat, fire_adr,
                    (fire_adr ? txn_q.addr : {ADDR_W{1'b0}}),
                    (fire_dat ? txn_q.data : {DATA_W{1'b0}})};
    end

    btt_rec_fifo #(
        .WIDTH (REC_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cap_push),
        .push_data (cap_rec),
        .pop       (rec_ready),
        .out_valid (rec_valid),
        .out_data  (head_rec),
        .overflow  (overflow)
    );

    assign rec_tag  = head_rec[REC_W-1 -: 2];
    assign rec_addr = head_rec[DATA_W +: ADDR_W];
    assign rec_data = head_rec[DATA_W-1:0];

endmodule

// File: rtl/bus_trace_trig_chk.sv
module bus_trace_trig_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic              rec_valid,
    input logic              rec_ready,
    input logic [1:0]        rec_tag,
    input logic [ADDR_W-1:0] rec_addr,
    input logic [DATA_W-1:0] rec_data,
    input logic              overflow
);

    assert_tag_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (rec_tag != 2'b00));

    // R6 also: a fresh record traces back to a write two edges earlier
    assert_rise_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !$past(rec_valid)) |-> $past(bus_valid && bus_write, 2));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_tag)
                                       && $stable(rec_addr) && $stable(rec_data)));

    assert_no_overflow_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

bind bus_trace_trig bus_trace_trig_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .rec_valid (rec_valid),
    .rec_ready (rec_ready),
    .rec_tag   (rec_tag),
    .rec_addr  (rec_addr),
    .rec_data  (rec_data),
    .overflow  (overflow)
);

// File: tb/bus_trace_trig_tb_top.sv
module bus_trace_trig_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int MW = 4;
    localparam int NW = 2;
    localparam int NE = 4;
    localparam int NT = NW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_write = 1'b0;
    logic [MW-1:0] bus_mid = '0;
    logic [NW-1:0] cfg_win_en = '0;
    logic [NW*AW-1:0] cfg_win_lo = '0;
    logic [NW*AW-1:0] cfg_win_hi = '0;
    logic          cfg_mid_en = 1'b0;
    logic [MW-1:0] cfg_mid_ref = '0;
    logic [MW-1:0] cfg_mid_mask = '0;
    logic [1:0]    cfg_mid_mode = '0;
    logic [NE*NT-1:0] cfg_evt_map = '0;
    logic [NE-1:0] cfg_route_adr = '0;
    logic [NE-1:0] cfg_route_dat = '0;
    logic          rec_valid;
    logic          rec_ready = 1'b1;
    logic [1:0]    rec_tag;
    logic [AW-1:0] rec_addr;
    logic [DW-1:0] rec_data;
    logic          overflow;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [1:0]    tag;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_trace_trig dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] model_tag(input logic [AW-1:0] a,
                                             input logic wr, input logic [MW-1:0] mid);
        logic [NT-1:0] t;
        logic [MW-1:0] m, r;
        logic adr, dat, rel;
        logic [NT-1:0] sel;
        if (!wr) return 2'b00;
        for (int k = 0; k < NW; k++)
            t[k] = cfg_win_en[k] && a >= cfg_win_lo[k*AW +: AW] && a <= cfg_win_hi[k*AW +: AW];
        m = mid & cfg_mid_mask;
        r = cfg_mid_ref & cfg_mid_mask;
        case (cfg_mid_mode)
            2'd0: rel = (m == r);
            2'd1: rel = (m >= r);
            2'd2: rel = (m <= r);
            default: rel = (m != r);
        endcase
        t[NW] = cfg_mid_en && rel;
        adr = 1'b0;
        dat = 1'b0;
        for (int e = 0; e < NE; e++) begin
            sel = cfg_evt_map[e*NT +: NT];
            if (sel != 0 && (t & sel) == sel) begin
                adr |= cfg_route_adr[e];
                dat |= cfg_route_dat[e];
            end
        end
        return {dat, adr};
    endfunction

    // driver: one transaction, expected record pushed to the scoreboard
    task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic wr, input logic [MW-1:0] mid,
                        input string req, input bit keep = 1'b1);
        exp_t x;
        @(negedge clk);
        bus_valid = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        bus_write = wr;
        bus_mid   = mid;
        x.tag  = model_tag(a, wr, mid);
        x.addr = x.tag[0] ? a : '0;
        x.data = x.tag[1] ? d : '0;
        x.req  = req;
        if (x.tag != 2'b00 && keep) exp_q.push_back(x);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, req, "missing records", 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    // monitor: compare each consumed record against the queue head
    always @(negedge clk) begin
        if (rst_n && rec_valid && rec_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected record addr", 64'(rec_addr), 64'd0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(rec_tag == x.tag, x.req, "tag", 64'(rec_tag), 64'(x.tag));
                check(rec_addr == x.addr, x.req, "addr", 64'(rec_addr), 64'(x.addr));
                check(rec_data == x.data, x.req, "data", 64'(rec_data), 64'(x.data));
            end
        end
    end

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(rec_valid == 1'b0, "R9", "rec_valid after reset", 64'(rec_valid), 64'd0);
        check(overflow == 1'b0, "R9", "overflow after reset", 64'(overflow), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_win_en = 2'b11;
        cfg_win_lo = {32'h0000_2000, 32'h0000_1000};
        cfg_win_hi = {32'h0000_2003, 32'h0000_10FF};
        cfg_mid_en = 1'b1; cfg_mid_ref = 4'h2; cfg_mid_mask = 4'hF; cfg_mid_mode = 2'd0;
        cfg_evt_map = '0;
        cfg_evt_map[0*NT + 0] = 1'b1;                       // event 0: window 0
        cfg_evt_map[1*NT + 1] = 1'b1;                       // event 1: window 1 AND master
        cfg_evt_map[1*NT + NW] = 1'b1;
        cfg_route_adr = 4'b0011;
        cfg_route_dat = 4'b0011;

        // R1: inclusive bounds, any master
        send(32'h0000_1000, 32'hAAAA_0001, 1'b1, 4'h7, "R1");
        send(32'h0000_10FF, 32'hAAAA_0002, 1'b1, 4'h0, "R1");
        send(32'h0000_0FFF, 32'hAAAA_0003, 1'b1, 4'h2, "R1");
        send(32'h0000_1100, 32'hAAAA_0004, 1'b1, 4'h2, "R1");
        drain("R1");

        // R5: a read in the window produces nothing
        send(32'h0000_1010, 32'hBBBB_0001, 1'b0, 4'h2, "R5");
        send(32'h0000_1020, 32'hBBBB_0002, 1'b1, 4'h2, "R5");
        drain("R5");

        // R1: disabled window keeps its trigger low
        cfg_win_en = 2'b10;
        send(32'h0000_1000, 32'hCCCC_0001, 1'b1, 4'h2, "R1");
        drain("R1");
        cfg_win_en = 2'b11;

        // R3: window AND master, each alone is not enough
        send(32'h0000_2000, 32'hDDDD_0001, 1'b1, 4'h2, "R3");
        send(32'h0000_2003, 32'hDDDD_0002, 1'b1, 4'h3, "R3");
        send(32'h0000_3000, 32'hDDDD_0003, 1'b1, 4'h2, "R3");
        drain("R3");

        // R2: masked magnitude modes, event 1 on master only
        cfg_evt_map = '0;
        cfg_evt_map[1*NT + NW] = 1'b1;
        cfg_mid_mask = 4'hC; cfg_mid_ref = 4'h4;
        cfg_mid_mode = 2'd1;
        send(32'h0000_9000, 32'hEEEE_0001, 1'b1, 4'h5, "R2");
        send(32'h0000_9004, 32'hEEEE_0002, 1'b1, 4'h3, "R2");
        drain("R2");
        cfg_mid_mode = 2'd2;
        send(32'h0000_9008, 32'hEEEE_0003, 1'b1, 4'h9, "R2");
        send(32'h0000_900C, 32'hEEEE_0004, 1'b1, 4'h2, "R2");
        drain("R2");
        cfg_mid_mode = 2'd3;
        send(32'h0000_9010, 32'hEEEE_0005, 1'b1, 4'h6, "R2");
        send(32'h0000_9014, 32'hEEEE_0006, 1'b1, 4'hA, "R2");
        drain("R2");
        cfg_mid_en = 1'b0;
        send(32'h0000_9018, 32'hEEEE_0007, 1'b1, 4'hA, "R2");
        drain("R2");
        cfg_mid_en = 1'b1; cfg_mid_mask = 4'hF; cfg_mid_ref = 4'h2; cfg_mid_mode = 2'd0;

        // R3: routed event with empty selection never fires
        cfg_evt_map = '0;
        cfg_route_adr = 4'b0100;
        cfg_route_dat = 4'b0100;
        send(32'h0000_1000, 32'h1111_0001, 1'b1, 4'h2, "R3");
        drain("R3");

        // R4: separate routes give address-only and data-only tags
        cfg_evt_map = '0;
        cfg_evt_map[0*NT + 0] = 1'b1;
        cfg_evt_map[1*NT + 1] = 1'b1;
        cfg_route_adr = 4'b0001;
        cfg_route_dat = 4'b0010;
        send(32'h0000_1040, 32'h2222_0001, 1'b1, 4'h1, "R4");
        send(32'h0000_2001, 32'h2222_0002, 1'b1, 4'h1, "R4");
        drain("R4");
        cfg_route_adr = 4'b0011;
        cfg_route_dat = 4'b0011;

        // R6: latency of two edges
        rec_ready = 1'b0;
        send(32'h0000_1080, 32'h3333_0001, 1'b1, 4'h2, "R6");
        check(rec_valid == 1'b0, "R6", "rec_valid one edge after", 64'(rec_valid), 64'd0);
        @(negedge clk);
        check(rec_valid == 1'b1, "R6", "rec_valid two edges after", 64'(rec_valid), 64'd1);
        rec_ready = 1'b1;
        drain("R6");

        // R7/R8: fill while stalled, drop the ninth
        rec_ready = 1'b0;
        for (int i = 0; i < 8; i++)
            send(32'h0000_1000 + 32'(i*4), 32'h4444_0000 + 32'(i), 1'b1, 4'h2, "R7");
        repeat (2) @(negedge clk);
        check(overflow == 1'b0, "R8", "overflow at exactly full", 64'(overflow), 64'd0);
        check(rec_tag == 2'd3 && rec_addr == 32'h0000_1000, "R7", "head held",
              64'(rec_addr), 64'h1000);
        send(32'h0000_10F0, 32'h4444_00FF, 1'b1, 4'h2, "R8", 1'b0);
        @(negedge clk);
        check(overflow == 1'b1, "R8", "overflow after drop", 64'(overflow), 64'd1);
        rec_ready = 1'b1;
        drain("R7");
        check(overflow == 1'b1, "R8", "overflow sticky", 64'(overflow), 64'd1);
        check(rec_valid == 1'b0, "R8", "dropped record absent", 64'(rec_valid), 64'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule